// File: doc/BRIEF.md
# Mode-Banked Register File with Packed Program Counter and Status

This block is the architectural register store of a 32-bit processor core that runs in one of four operating modes. The datapath always addresses sixteen logical registers, index 0 to 15. Behind that view, the block holds a larger set of physical registers. The physical register that answers for a given index depends on the current mode. Some modes own private copies of some registers. Every register that a mode does not own resolves to the shared user copy.

Register 15 is a single register shared by all modes. It packs three things into one word: a word-aligned program counter, the six status flags and the two mode bits. The mode that selects the banks is therefore the value held in register 15.

The datapath uses the block through these paths:
- two combinational read ports;
- one write port;
- a link path, which stores a return address into the current mode's register 14 on a branch-and-link;
- a PC step input, which advances the program counter by one word.

A user-bank override input makes the read and write ports reach the user copies from any mode. Multi-register transfers use it.

Top module: `modal_regfile`

## Requirements
- R1: A cycle with `rst_n` low at the clock edge leaves the block in this state: register 15 reads 0x0C000003 (supervisor mode, both interrupt-disable bits set, PC and N/Z/C/V zero), and every other register reads zero.
- R2: The mode is held in register 15 bits [1:0], encoded 00 = user, 01 = IRQ, 10 = FIQ, 11 = supervisor. In user mode, indices 0 to 14 reach the shared user copies. `mode_out` mirrors bits [1:0].
- R3: In FIQ mode, indices from `FIQ_FIRST` (default 8) up to 14 reach FIQ-private copies. Lower indices reach the user copies.
- R4: IRQ mode and supervisor mode each own private copies of indices 13 and 14 only. All other indices reach the user copies.
- R5: Register 15 is laid out as N=31, Z=30, C=29, V=28, IRQ-disable=27, FIQ-disable=26, PC word address=[25:2], mode=[1:0]. Reading index 15 returns this word in every mode. `r15_out` shows its registered value.
- R6: A write to index 15 made in user mode changes only bits [31:28] and [25:2]. Bits [27:26] and [1:0] keep their values.
- R7: A write to index 15 made in a privileged mode replaces all 32 bits. A new mode selects the banks from the next cycle on. Writes in the same cycle use the old mode's banks.
- R8: `link_en` stores `link_data` into register 14 of the current mode's bank, and `user_bank` does not redirect it. If the write port targets the same physical register in the same cycle, the write port's value is kept.
- R9: `pc_step` adds one to bits [25:2], wrapping from all ones to zero, and leaves the other bits unchanged. A write to index 15 in the same cycle takes priority over the step.
- R10: While `user_bank` is high, both read ports and the write port reach the user copies for indices 0 to 14, whatever the mode.
- R11: A read of a register that is written in the same cycle returns the new value. A read of index 15 returns the value register 15 will hold after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data (with write-through) |
| rd_b_sel | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data (with write-through) |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 4 | Write port logical index |
| wr_data | input | 32 | Write port data |
| link_en | input | 1 | Store return address into current-mode register 14 |
| link_data | input | 32 | Return address |
| pc_step | input | 1 | Advance PC by one word |
| user_bank | input | 1 | Force ports to the user copies |
| r15_out | output | 32 | Registered PC/flags/mode word |
| mode_out | output | 2 | Current mode |

## Verification
Three kinds of event can land in the same cycle: a port write, a link store, and a read of the register that either of them is changing. A write to index 15 can also meet a PC step in one cycle. Random stimulus steers read indices onto the write index on purpose and raises `link_en` together with writes to index 14. Each read is then compared against a bench model that resolves the physical target, applies write-over-link priority and forwards the incoming value.

Directed steps cover these cases:
- a link colliding with a write in FIQ mode;
- a user-mode write to register 15, which must keep the interrupt-disable and mode bits;
- a PC step wrapping from all ones to zero.

// File: rtl/modal_regfile_pkg.sv
// Package: shared mode encoding and the bit layout of the packed register 15.
// Assumes a 32-bit data word; the layout of register 15 fills it exactly.
package modal_regfile_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        MODE_USR = 2'b00,
        MODE_IRQ = 2'b01,
        MODE_FIQ = 2'b10,
        MODE_SVC = 2'b11
    } cpu_mode_e;

    localparam int FLAG_HI = 31;   // N Z C V occupy [31:28]
    localparam int FLAG_LO = 28;
    localparam int MASK_HI = 27;   // IRQ-disable, FIQ-disable occupy [27:26]
    localparam int MASK_LO = 26;
    localparam int PC_HI   = 25;
    localparam int PC_LO   = 2;
    localparam int MODE_HI = 1;
    localparam int MODE_LO = 0;

    localparam logic [DATA_W-1:0] R15_AT_RESET = 32'h0C00_0003;

endpackage

// File: rtl/mrf_bank_map.sv
// Module: translates a logical register index and a mode into a physical slot.
// Slot layout: user copies 0..14, then FIQ copies, then IRQ 13/14, then SVC 13/14.
// Assumes FIQ_FIRST lies in 8..13. Index 15 is flagged and gets slot zero.
module mrf_bank_map
    import modal_regfile_pkg::*;
#(
    parameter int FIQ_FIRST = 8,
    parameter int PW        = 5
) (
    input  logic [SEL_W-1:0] idx,
    input  cpu_mode_e        mode,
    output logic [PW-1:0]    phys,
    output logic             is_pc
);
    localparam int NFIQ     = 15 - FIQ_FIRST;
    localparam int FIQ_BASE = 15;
    localparam int IRQ_BASE = FIQ_BASE + NFIQ;
    localparam int SVC_BASE = IRQ_BASE + 2;

    // Pick the physical slot for this index under this mode.
    always_comb begin
        is_pc = (idx == 4'd15);
        phys  = is_pc ? '0 : PW'(idx);
        unique case (mode)
            MODE_FIQ: if (!is_pc && int'(idx) >= FIQ_FIRST)
                          phys = PW'(FIQ_BASE + int'(idx) - FIQ_FIRST);
            MODE_IRQ: if (idx == 4'd13 || idx == 4'd14)
                          phys = PW'(IRQ_BASE + int'(idx) - 13);
            MODE_SVC: if (idx == 4'd13 || idx == 4'd14)
                          phys = PW'(SVC_BASE + int'(idx) - 13);
            default:  ;
        endcase
    end
endmodule

// File: rtl/mrf_gpr_store.sv
// Module: physical storage for the banked general registers.
// Two write ports: A (the datapath write) has priority over B (link store).
// Reads forward a same-cycle write; A's value wins when both hit the slot.
module mrf_gpr_store
    import modal_regfile_pkg::*;
#(
    parameter int NPHYS = 26,
    parameter int PW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  logic [PW-1:0]     wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [PW-1:0]     wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [PW-1:0]     ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [PW-1:0]     rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs [NPHYS];

    function automatic logic [DATA_W-1:0] fwd(input logic [PW-1:0] i);
        if (wa_en && wa_idx == i) return wa_data;
        if (wb_en && wb_idx == i) return wb_data;
        return regs[i];
    endfunction

    // Clear all slots on reset; otherwise apply B then A so A wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NPHYS; k++) regs[k] <= '0;
        end else begin
            if (wb_en) regs[wb_idx] <= wb_data;
            if (wa_en) regs[wa_idx] <= wa_data;
        end
    end

    // Combinational reads with write-through.
    always_comb begin
        ra_data = fwd(ra_idx);
        rb_data = fwd(rb_idx);
    end

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_idx == wb_idx) |=> regs[$past(wa_idx)] == $past(wa_data));

    assert_link_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(wa_en && wa_idx == wb_idx)) |=> regs[$past(wb_idx)] == $past(wb_data));

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en |=> regs[$past(wa_idx)] == $past(wa_data));
endmodule

// File: rtl/mrf_status_reg.sv
// Module: the packed register 15 (PC, flags, mode) and its update rules.
// Assumes wr_en is already qualified to mean "write port targets index 15".
// Exposes the next-state value so reads can forward it.
module mrf_status_reg
    import modal_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_step,
    output logic [DATA_W-1:0] r15_q,
    output logic [DATA_W-1:0] r15_d
);
    logic user_mode;
    assign user_mode = (cpu_mode_e'(r15_q[MODE_HI:MODE_LO]) == MODE_USR);

    // Next value: a write beats a step; user mode may not alter masks or mode.
    always_comb begin
        r15_d = r15_q;
        if (wr_en) begin
            r15_d = wr_data;
            if (user_mode) begin
                r15_d[MASK_HI:MASK_LO] = r15_q[MASK_HI:MASK_LO];
                r15_d[MODE_HI:MODE_LO] = r15_q[MODE_HI:MODE_LO];
            end
        end else if (pc_step) begin
            r15_d[PC_HI:PC_LO] = r15_q[PC_HI:PC_LO] + 1'b1;
        end
    end

    // Hold the word; reset enters supervisor mode with interrupts masked.
    always_ff @(posedge clk) begin
        if (!rst_n) r15_q <= R15_AT_RESET;
        else        r15_q <= r15_d;
    end

    assert_user_keeps_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && user_mode) |=> (r15_q[MASK_HI:MASK_LO] == $past(r15_q[MASK_HI:MASK_LO]))
                                 && (r15_q[MODE_HI:MODE_LO] == MODE_USR));

    assert_priv_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !user_mode) |=> r15_q == $past(wr_data));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_step && !wr_en) |=> (r15_q[PC_HI:PC_LO] == $past(r15_q[PC_HI:PC_LO]) + 24'd1)
                                && (r15_q[FLAG_HI:MASK_LO] == $past(r15_q[FLAG_HI:MASK_LO]))
                                && (r15_q[MODE_HI:MODE_LO] == $past(r15_q[MODE_HI:MODE_LO])));
endmodule

// File: rtl/modal_regfile.sv
// Module: top of the mode-banked register file.
// Four index lookups (read A, read B, write, link) resolve physical slots; index 15
// goes to the packed status register. The link lookup always uses the real mode.
module modal_regfile
    import modal_regfile_pkg::*;
#(
    parameter int FIQ_FIRST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_sel,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_sel,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              link_en,
    input  logic [31:0]       link_data,
    input  logic              pc_step,
    input  logic              user_bank,
    output logic [31:0]       r15_out,
    output logic [1:0]        mode_out
);
    localparam int NFIQ  = 15 - FIQ_FIRST;
    localparam int NPHYS = 15 + NFIQ + 4;
    localparam int PW    = $clog2(NPHYS);
    localparam int NLK   = 4;           // lookups: 0 read A, 1 read B, 2 write, 3 link

    logic [DATA_W-1:0] r15_q, r15_d;
    logic [DATA_W-1:0] gpr_a, gpr_b;
    cpu_mode_e         cur_mode, acc_mode;

    logic [SEL_W-1:0]  lk_idx  [NLK];
    cpu_mode_e         lk_mode [NLK];
    logic [PW-1:0]     lk_phys [NLK];
    logic              lk_pc   [NLK];

    // Mode that port accesses see, honouring the user-bank override.
    always_comb begin
        cur_mode = cpu_mode_e'(r15_q[MODE_HI:MODE_LO]);
        acc_mode = user_bank ? MODE_USR : cur_mode;
        lk_idx[0] = rd_a_sel;  lk_mode[0] = acc_mode;
        lk_idx[1] = rd_b_sel;  lk_mode[1] = acc_mode;
        lk_idx[2] = wr_sel;    lk_mode[2] = acc_mode;
        lk_idx[3] = 4'd14;     lk_mode[3] = cur_mode;
    end

    for (genvar g = 0; g < NLK; g++) begin : g_map
        mrf_bank_map #(.FIQ_FIRST(FIQ_FIRST), .PW(PW)) u_map (
            .idx   (lk_idx[g]),
            .mode  (lk_mode[g]),
            .phys  (lk_phys[g]),
            .is_pc (lk_pc[g])
        );
    end

    mrf_gpr_store #(.NPHYS(NPHYS), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wr_en && !lk_pc[2]),
        .wa_idx  (lk_phys[2]),
        .wa_data (wr_data),
        .wb_en   (link_en && !lk_pc[3]),
        .wb_idx  (lk_phys[3]),
        .wb_data (link_data),
        .ra_idx  (lk_phys[0]),
        .ra_data (gpr_a),
        .rb_idx  (lk_phys[1]),
        .rb_data (gpr_b)
    );

    mrf_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && lk_pc[2]),
        .wr_data (wr_data),
        .pc_step (pc_step),
        .r15_q   (r15_q),
        .r15_d   (r15_d)
    );

    // Read mux: index 15 forwards the next status word, others the store.
    always_comb begin
        rd_a_data = lk_pc[0] ? r15_d : gpr_a;
        rd_b_data = lk_pc[1] ? r15_d : gpr_b;
        r15_out   = r15_q;
        mode_out  = r15_q[MODE_HI:MODE_LO];
    end

    assert_link_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (user_bank && cur_mode != MODE_USR) |-> (lk_phys[3] != lk_phys[2]) || !(wr_sel == 4'd14));
endmodule

// File: tb/modal_regfile_bench.sv
// Bench: random plus directed stimulus against a slot-keyed reference model.
module modal_regfile_bench;
    localparam int FIQ_LO = 8;
    localparam int PCS    = 999;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, link_data = '0, r15_out;
    logic        wr_en = 0, link_en = 0, pc_step = 0, user_bank = 0;
    logic [1:0]  mode_out;

    modal_regfile #(.FIQ_FIRST(FIQ_LO)) u_modal_regfile (
        .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .link_en(link_en), .link_data(link_data), .pc_step(pc_step),
        .user_bank(user_bank), .r15_out(r15_out), .mode_out(mode_out));

    logic [31:0] m_regs [0:399];
    logic [31:0] m_r15;
    int n_vec = 0, n_bad = 0;
    string r15_tag = "R1";
    bit finished = 0;

    function automatic int slot(input logic [3:0] idx, input logic [1:0] m);
        if (idx == 4'd15) return PCS;
        if (m == 2'b10 && int'(idx) >= FIQ_LO) return 100 + int'(idx);
        if (m == 2'b01 && idx >= 4'd13) return 200 + int'(idx);
        if (m == 2'b11 && idx >= 4'd13) return 300 + int'(idx);
        return int'(idx);
    endfunction

    function automatic logic [31:0] next_r15(input logic we, input logic [3:0] ws,
                                             input logic [31:0] wd, input logic inc);
        logic [31:0] v = m_r15;
        if (we && ws == 4'd15) begin
            if (m_r15[1:0] == 2'b00) v = {wd[31:28], m_r15[27:26], wd[25:2], m_r15[1:0]};
            else v = wd;
        end else if (inc) v[25:2] = m_r15[25:2] + 24'd1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 400; k++) m_regs[k] = '0;
        m_r15 = 32'h0C00_0003;
    endtask

    task automatic step(input logic rst, input logic we, input logic [3:0] ws,
                        input logic [31:0] wd, input logic le, input logic [31:0] ld,
                        input logic inc, input logic ub, input logic [3:0] ra,
                        input logic [3:0] rb, input string force_tag);
        logic [1:0]  m, em;
        logic [31:0] nr15, ea, eb;
        int wsl, lsl, asl, bsl;
        string ta, tb;
        @(negedge clk);
        chk(r15_tag, r15_out, m_r15);
        chk("R2", {30'd0, mode_out}, {30'd0, m_r15[1:0]});
        rst_n = !rst; wr_en = we; wr_sel = ws; wr_data = wd; link_en = le;
        link_data = ld; pc_step = inc; user_bank = ub; rd_a_sel = ra; rd_b_sel = rb;
        #1;
        m = m_r15[1:0];
        em = ub ? 2'b00 : m;
        wsl = slot(ws, em); lsl = slot(4'd14, m);
        asl = slot(ra, em); bsl = slot(rb, em);
        nr15 = next_r15(we, ws, wd, inc);
        if (!rst) begin
            ea = (asl == PCS) ? nr15 : (we && asl == wsl) ? wd : (le && asl == lsl) ? ld : m_regs[asl];
            eb = (bsl == PCS) ? nr15 : (we && bsl == wsl) ? wd : (le && bsl == lsl) ? ld : m_regs[bsl];
            ta = ((we && asl == wsl) || (le && asl == lsl) || asl == PCS) ? "R11" : ub ? "R10" :
                 (m == 2'b10) ? "R3" : (m == 2'b00) ? "R2" : "R4";
            tb = ((we && bsl == wsl) || (le && bsl == lsl) || bsl == PCS) ? "R11" : ub ? "R10" :
                 (m == 2'b10) ? "R3" : (m == 2'b00) ? "R2" : "R4";
            if (force_tag != "") begin ta = force_tag; tb = force_tag; end
            chk(ta, rd_a_data, ea);
            chk(tb, rd_b_data, eb);
        end
        @(posedge clk);
        if (rst) begin
            model_reset();
            r15_tag = "R1";
        end else begin
            if (le) m_regs[lsl] = ld;
            if (we && wsl != PCS) m_regs[wsl] = wd;
            r15_tag = (we && ws == 4'd15) ? ((m == 2'b00) ? "R6" : "R7") : inc ? "R9" : "R5";
            m_r15 = nr15;
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        model_reset();
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        // R1: reset contents
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'd15, 4'd13, "R1");
        // R7: privileged write to FIQ mode
        step(0, 1, 4'd15, 32'h0C00_0002, 0, 0, 0, 0, 4'd0, 4'd1, "");
        // R3: FIQ-private R8
        step(0, 1, 4'd8, 32'hAAAA_0008, 0, 0, 0, 0, 4'd8, 4'd7, "");
        // R8: link collides with write to R14, write wins
        step(0, 1, 4'd14, 32'h1111_2222, 1, 32'h0000_1234, 0, 0, 4'd14, 4'd8, "R8");
        step(0, 0, 0, 0, 1, 32'h0000_5678, 0, 1, 4'd14, 4'd8, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'd14, 4'd8, "R8");
        // R10: override reads user R8, R14
        step(0, 0, 0, 0, 0, 0, 0, 1, 4'd8, 4'd14, "R10");
        // R7: drop to user mode
        step(0, 1, 4'd15, 32'hF3FF_FFFC, 0, 0, 0, 0, 4'd8, 4'd14, "");
        // R6: user write must keep masks and mode
        step(0, 1, 4'd15, 32'h0FFF_FFFF, 0, 0, 1, 0, 4'd15, 4'd8, "R6");
        // R9: step wraps PC from all ones
        step(0, 0, 0, 0, 0, 0, 1, 0, 4'd15, 4'd0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'd15, 4'd0, "R5");
        for (int i = 0; i < 4000; i++) begin
            logic we, le, inc, ub, rst;
            logic [3:0] ws, ra, rb;
            we  = ($urandom % 2) == 0;
            ws  = (($urandom % 8) == 0) ? 4'd15 : 4'($urandom % 15);
            le  = (($urandom % 4) == 0);
            inc = (($urandom % 3) == 0);
            ub  = (($urandom % 5) == 0);
            ra  = (($urandom % 3) == 0) ? ws : 4'($urandom % 16);
            rb  = (($urandom % 4) == 0) ? 4'd14 : 4'($urandom % 16);
            rst = (m_r15[1:0] == 2'b00) && (($urandom % 8) == 0);
            step(rst, we, ws, $urandom, le, $urandom, inc, ub, ra, rb, "");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule